// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control unit of a small 16-bit processor that keeps instructions and data in separate memories. It holds the program counter and the instruction register. It fetches one 16-bit word at a time from a synchronous instruction ROM and decodes the 4-bit opcode. It then drives the external datapath through a fixed sequence of cycles: register-file addresses and write enable, data-memory address and write enable, an add/subtract select for the ALU, and a writeback select that picks memory read data or the ALU result.

Every instruction passes through a fetch cycle, a decode cycle and an execute cycle. The memory-to-register transfer takes one extra execute cycle, because the data RAM returns its read word one clock after it is addressed. A halt instruction parks the controller in a state that only reset leaves. The register file, the ALU and both memories sit outside the block.

Top module: `insn_sequencer`

## Requirements
- R1: While reset is held and in the cycle after it, `rom_addr` is 0, `rf_wr_en` and `dm_wr_en` are 0 and `halted` is 0.
- R2: The opcode is taken from instruction bits 15:12. Code 0000 and the unused codes 0110 to 1111 cause no register or memory write and take three cycles.
- R3: Code 0011 (add) and code 0100 (subtract) read registers from bits 11:8 (A) and 7:4 (B) and write A+B or A−B into the register in bits 3:0. `alu_sub` is 1 only for subtract, and `wb_sel_mem` is 0 on the write.
- R4: Code 0001 loads the data word at the address in bits 7:0 into the register in bits 11:8. The register write comes one cycle after the address is presented, with `wb_sel_mem`=1.
- R5: Code 0010 writes the register named in bits 3:0 to the data address in bits 11:4. The register is read on `rf_rd_a` and the write happens in one execute cycle.
- R6: From the end of reset, add, subtract, code 0010, 0000 and unused codes take 3 clock cycles each and code 0001 takes 4. A halt reaches `halted`=1 three cycles after its fetch begins, and the first fetch starts one cycle after reset is released.
- R7: Code 0101 sets `halted`. After that, `rom_addr` stays frozen and both write enables stay 0 until reset. A reset restarts execution from address 0.
- R8: The program counter only ever steps by +1, once per instruction, and the instruction register changes only when a new word is loaded.
- R9: `rf_wr_en` and `dm_wr_en` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rom_addr | output | 7 | Instruction ROM address (program counter) |
| rom_data | input | 16 | ROM read word, valid one cycle after the address |
| rf_rd_a | output | 4 | Register-file read address A (ALU A, store data) |
| rf_rd_b | output | 4 | Register-file read address B |
| rf_wr_addr | output | 4 | Register-file write address |
| rf_wr_en | output | 1 | Register-file write enable |
| dm_addr | output | 8 | Data RAM address |
| dm_wr_en | output | 1 | Data RAM write enable |
| alu_sub | output | 1 | ALU select: 1 subtract, 0 add |
| wb_sel_mem | output | 1 | Writeback select: 1 RAM read data, 0 ALU result |
| halted | output | 1 | Controller is parked in the halt state |

## Verification
The hardest situation to reach is a load from data memory whose target register is read by the very next instruction. The extra execute cycle and the RAM latency only show up as a wrong value when the following add, subtract or store depends on that register. The random programs draw register and address fields from small ranges so that such dependencies happen often, and the final register file and RAM are compared against an instruction-level model. The same programs check the total cycle count up to `halted`, so a missing or extra cycle in any instruction class shows up as a count mismatch.

// File: rtl/insn_seq_pkg.sv
// Shared opcode codes and state encoding for the instruction sequencer.
// Assumes a 16-bit instruction word with the opcode in bits 15:12.
package insn_seq_pkg;
    localparam int IW      = 16;
    localparam int OP_W    = 4;
    localparam int REG_W   = 4;
    localparam int DADDR_W = 8;

    localparam logic [OP_W-1:0] OP_NOP  = 4'b0000;
    localparam logic [OP_W-1:0] OP_M2R  = 4'b0001;
    localparam logic [OP_W-1:0] OP_R2M  = 4'b0010;
    localparam logic [OP_W-1:0] OP_ADD  = 4'b0011;
    localparam logic [OP_W-1:0] OP_SUB  = 4'b0100;
    localparam logic [OP_W-1:0] OP_HALT = 4'b0101;

    typedef enum logic [2:0] {
        ST_RST    = 3'd0,
        ST_FETCH  = 3'd1,
        ST_DECODE = 3'd2,
        ST_EXEC   = 3'd3,
        ST_EXEC2  = 3'd4,
        ST_HALT   = 3'd5
    } seq_state_t;
endpackage

// File: rtl/seq_pc.sv
// Program counter: clears on reset and steps by one when inc is high.
// Assumes the counter wraps modulo 2**PC_W.
module seq_pc #(
    parameter int PC_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    output logic [PC_W-1:0] pc
);
    logic [PC_W-1:0] pc_q;

    // Counter register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pc_q <= '0;
        else if (inc) pc_q <= pc_q + 1'b1;
    end

    assign pc = pc_q;

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pc_q) |-> (pc_q == PC_W'($past(pc_q) + 1'b1)));
endmodule

// File: rtl/seq_ir.sv
// Instruction register: captures the ROM word when ld is high.
// Assumes ld is only raised while the ROM output is valid.
module seq_ir #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] ir_q;

    // Holding register, cleared to a no-operation word.
    always_ff @(posedge clk) begin
        if (!rst_n)  ir_q <= '0;
        else if (ld) ir_q <= d;
    end

    assign q = ir_q;

    // R8
    ir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ld) |-> $stable(ir_q));
endmodule

// File: rtl/seq_fsm.sv
// Fetch/decode/execute state machine and combinational decode.
// Assumes a synchronous ROM and RAM (one cycle read latency) and a
// register file with combinational read ports.
module seq_fsm
    import insn_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IW-1:0]      ir,
    output logic               ir_ld,
    output logic               pc_inc,
    output logic [REG_W-1:0]   rf_rd_a,
    output logic [REG_W-1:0]   rf_rd_b,
    output logic [REG_W-1:0]   rf_wr_addr,
    output logic               rf_wr_en,
    output logic [DADDR_W-1:0] dm_addr,
    output logic               dm_wr_en,
    output logic               alu_sub,
    output logic               wb_sel_mem,
    output logic               halted
);
    seq_state_t state_q, state_d;
    logic [OP_W-1:0] op;

    assign op = ir[15:12];

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RST:    state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                if (op == OP_HALT)     state_d = ST_HALT;
                else if (op == OP_M2R) state_d = ST_EXEC2;
                else                   state_d = ST_FETCH;
            end
            ST_EXEC2:  state_d = ST_FETCH;
            ST_HALT:   state_d = ST_HALT;
            default:   state_d = ST_RST;
        endcase
    end

    // Datapath controls decoded from state and instruction fields.
    always_comb begin
        ir_ld      = 1'b0;
        pc_inc     = 1'b0;
        rf_rd_a    = '0;
        rf_rd_b    = '0;
        rf_wr_addr = '0;
        rf_wr_en   = 1'b0;
        dm_addr    = '0;
        dm_wr_en   = 1'b0;
        alu_sub    = 1'b0;
        wb_sel_mem = 1'b0;
        if (state_q == ST_DECODE) begin
            ir_ld  = 1'b1;
            pc_inc = 1'b1;
        end else if (state_q == ST_EXEC) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    rf_rd_a    = ir[11:8];
                    rf_rd_b    = ir[7:4];
                    rf_wr_addr = ir[3:0];
                    rf_wr_en   = 1'b1;
                    alu_sub    = (op == OP_SUB);
                end
                OP_M2R: dm_addr = ir[7:0];
                OP_R2M: begin
                    rf_rd_a  = ir[3:0];
                    dm_addr  = ir[11:4];
                    dm_wr_en = 1'b1;
                end
                default: ;
            endcase
        end else if (state_q == ST_EXEC2) begin
            dm_addr    = ir[7:0];
            rf_wr_addr = ir[11:8];
            rf_wr_en   = 1'b1;
            wb_sel_mem = 1'b1;
        end
    end

    assign halted = (state_q == ST_HALT);

    // R7
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT) |=> (state_q == ST_HALT));
    // R7
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!rf_wr_en && !dm_wr_en && !pc_inc));
    // R9
    one_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rf_wr_en && dm_wr_en));
    // R6
    m2r_extra_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && op == OP_M2R) |=> (state_q == ST_EXEC2 && wb_sel_mem));
    // R1
    rst_idle_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (state_q == ST_RST));
endmodule

// File: rtl/insn_sequencer.sv
// Top of the multicycle controller: joins PC, IR and the state machine.
// Assumes ROM data arrives one clock after rom_addr is presented.
module insn_sequencer #(
    parameter int PC_W = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [PC_W-1:0] rom_addr,
    input  logic [15:0] rom_data,
    output logic [3:0]  rf_rd_a,
    output logic [3:0]  rf_rd_b,
    output logic [3:0]  rf_wr_addr,
    output logic        rf_wr_en,
    output logic [7:0]  dm_addr,
    output logic        dm_wr_en,
    output logic        alu_sub,
    output logic        wb_sel_mem,
    output logic        halted
);
    import insn_seq_pkg::*;

    logic          ir_ld, pc_inc;
    logic [IW-1:0] ir_q;

    seq_pc #(.PC_W(PC_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .inc(pc_inc), .pc(rom_addr)
    );

    seq_ir #(.W(IW)) u_ir (
        .clk(clk), .rst_n(rst_n), .ld(ir_ld), .d(rom_data), .q(ir_q)
    );

    seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ir(ir_q),
        .ir_ld(ir_ld), .pc_inc(pc_inc),
        .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b),
        .rf_wr_addr(rf_wr_addr), .rf_wr_en(rf_wr_en),
        .dm_addr(dm_addr), .dm_wr_en(dm_wr_en),
        .alu_sub(alu_sub), .wb_sel_mem(wb_sel_mem), .halted(halted)
    );
endmodule

// File: tb/test_insn_sequencer.sv
module test_insn_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  rom_addr;
    logic [15:0] rom_q;
    logic [3:0]  rf_rd_a, rf_rd_b, rf_wr_addr;
    logic        rf_wr_en, dm_wr_en, alu_sub, wb_sel_mem, halted;
    logic [7:0]  dm_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [15:0] rom_m [128];
    logic [15:0] ram_m [256];
    logic [15:0] rf_m  [16];
    logic [15:0] ram_q;
    logic [15:0] mrf   [16];
    logic [15:0] mram  [256];

    always #10 clk = ~clk;

    insn_sequencer i_insn_sequencer (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_q),
        .rf_rd_a(rf_rd_a), .rf_rd_b(rf_rd_b), .rf_wr_addr(rf_wr_addr),
        .rf_wr_en(rf_wr_en), .dm_addr(dm_addr), .dm_wr_en(dm_wr_en),
        .alu_sub(alu_sub), .wb_sel_mem(wb_sel_mem), .halted(halted)
    );

    // Behavioural ROM, RAM, register file and ALU around the block.
    always_ff @(posedge clk) begin
        rom_q <= rom_m[rom_addr];
        ram_q <= ram_m[dm_addr];
        if (dm_wr_en === 1'b1) ram_m[dm_addr] <= rf_m[rf_rd_a];
        if (rf_wr_en === 1'b1)
            rf_m[rf_wr_addr] <= wb_sel_mem ? ram_q :
                (alu_sub ? rf_m[rf_rd_a] - rf_m[rf_rd_b] : rf_m[rf_rd_a] + rf_m[rf_rd_b]);
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Instruction-level model: runs the ROM image, returns expected cycles to halted.
    function automatic int model_run();
        int cyc = 1;
        for (int i = 0; i < 16; i++)  mrf[i]  = rf_m[i];
        for (int i = 0; i < 256; i++) mram[i] = ram_m[i];
        for (int pc = 0; pc < 128; pc++) begin
            logic [15:0] w = rom_m[pc];
            case (w[15:12])
                4'h1: begin mrf[w[11:8]] = mram[w[7:0]]; cyc += 4; end
                4'h2: begin mram[w[11:4]] = mrf[w[3:0]]; cyc += 3; end
                4'h3: begin mrf[w[3:0]] = mrf[w[11:8]] + mrf[w[7:4]]; cyc += 3; end
                4'h4: begin mrf[w[3:0]] = mrf[w[11:8]] - mrf[w[7:4]]; cyc += 3; end
                4'h5: return cyc + 3;
                default: cyc += 3;
            endcase
        end
        return -1;
    endfunction

    function automatic logic [15:0] rand_insn();
        int k = $urandom % 8;
        logic [3:0] a = 4'($urandom % 4), b = 4'($urandom % 4), d = 4'($urandom % 4);
        logic [7:0] da = 8'($urandom % 6);
        case (k)
            0: return {4'h0, 12'($urandom)};
            1: return {4'h1, a, da};
            2: return {4'h2, da, d};
            3, 6: return {4'h3, a, b, d};
            4, 7: return {4'h4, a, b, d};
            default: return {4'(6 + $urandom % 10), 12'($urandom)};
        endcase
    endfunction

    task automatic init_data();
        for (int i = 0; i < 16; i++)  rf_m[i]  = 16'($urandom);
        for (int i = 0; i < 256; i++) ram_m[i] = 16'($urandom);
        for (int i = 0; i < 128; i++) rom_m[i] = {4'h5, 12'h000};
    endtask

    // Reset, run to halt, compare cycles, state and post-halt quiet.
    task automatic run_prog(input string tag);
        int exp_cyc, n;
        bit rf_ok, dm_ok, quiet;
        logic [6:0] frozen;
        exp_cyc = model_run();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1
        check({"R1 ", tag}, {rom_addr, rf_wr_en, dm_wr_en, halted}, 0);
        rst_n = 1'b1;
        n = 0;
        while (!halted && n < 3000) begin
            @(posedge clk); n++; @(negedge clk);
        end
        // R6
        check({"R6 cycles ", tag}, n, exp_cyc);
        rf_ok = 1'b1; dm_ok = 1'b1;
        for (int i = 0; i < 16; i++)  if (rf_m[i] !== mrf[i]) rf_ok = 1'b0;
        for (int i = 0; i < 256; i++) if (ram_m[i] !== mram[i]) dm_ok = 1'b0;
        // R2 R3 R4 register results
        check({"R3/R4 regfile ", tag}, rf_ok, 1);
        // R5
        check({"R5 data mem ", tag}, dm_ok, 1);
        frozen = rom_addr; quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rf_wr_en || dm_wr_en || !halted || rom_addr !== frozen) quiet = 1'b0;
        end
        // R7
        check({"R7 halt hold ", tag}, quiet, 1);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        init_data();
        // R7: halt at address 0
        run_prog("halt-first");
        // R2: NOOP and every unused code leave state untouched
        init_data();
        rom_m[0] = 16'h0FFF;
        for (int c = 6; c < 16; c++) rom_m[c - 5] = {4'(c), 12'hABC};
        rom_m[11] = 16'h5000;
        run_prog("R2 undefined");
        // R4 R5 R3 directed field positions and back-to-back dependency
        init_data();
        rom_m[0] = 16'h1A5C;   // r10 <- mem[5C]
        rom_m[1] = 16'h2C3A;   // mem[C3] <- r10
        rom_m[2] = 16'h4A3F;   // r15 <- r10 - r3
        rom_m[3] = 16'h3AF1;   // r1 <- r10 + r15
        rom_m[4] = 16'h5123;
        run_prog("directed");
        // Random programs
        for (int p = 0; p < 10; p++) begin
            int len = 5 + $urandom % 40;
            init_data();
            for (int i = 0; i < len; i++) rom_m[i] = rand_insn();
            rom_m[len] = {4'h5, 12'($urandom)};
            run_prog($sformatf("rand%0d", p));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule